// File: doc/BRIEF.md
# Serial Flash Linear Read Cache

This block lets a processor read a serial flash as if it were plain memory. Reads of a 32-bit word at any byte address are served from a single 1024-byte line. When the line covers the address, the word comes back one cycle after the request is accepted. Its four bytes start at the requested offset and are packed little-endian.

When the line does not cover the address, the request is held off and the block runs a refill. It raises a select output and sends a read command on a byte-wide transmit stream toward an SPI shifter. The command is an instruction byte, three address bytes, an optional mode byte, then zero-valued dummy bytes. Every byte returned during that command is dropped. It then clocks out zero bytes in 64-byte bursts and stores the 1024 returned bytes into the line. Finally it records the line base and answers the held request. A single 32-bit configuration word supplies the instruction, the mode byte and its enable, the dummy count, and the one-or-two bus selection. Writing that word invalidates the line.

Top module: `flash_read_cache`

## Requirements
- R1: After reset the configuration word holds 0x03A002EB. The first refill therefore sends instruction 0xEB, mode byte 0xA0 and two dummy bytes, in single-bus mode. After reset no response, select or transmit is active and no read is accepted.
- R2: A read is a hit when line base <= address <= line base + 1020 and the line is valid. A hit is accepted at once and answered with rsp_valid_o one cycle later, with no serial traffic.
- R3: Hit data is little-endian: bits 8k+7:8k hold line byte (address - base + k), for k = 0..3.
- R4: On a miss the flash address is the bus address in single-bus mode. It is the bus address shifted right by one when configuration bit 30 selects two buses.
- R5: The command starts with configuration bits 7:0, then flash address bits 23:16, 15:8 and 7:0.
- R6: When configuration bit 25 is set, configuration bits 23:16 are sent as one byte right after the address.
- R7: Configuration bits 10:8 give the count of 0x00 dummy bytes that follow. The refill then sends exactly header length + 1024 bytes.
- R8: Bytes received during the header are discarded, and the next 1024 received bytes fill the line in order. Data-phase bytes sent are 0x00. No more than 64 bytes are ever in flight, and a new 64-byte burst starts only after the previous burst has fully returned.
- R9: During a refill page_o is 1 exactly when flash address bits above bit 23 are nonzero. Outside a refill page_o follows page_i.
- R10: After a refill the line base is the flash address times the number of active buses.
- R11: A configuration write invalidates the line, and a refill that it overlaps does not validate the line.
- R12: A missing read keeps req_ready_o low while sel_o is high for the refill. It is accepted once the refill completes and the line covers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request present |
| req_addr_i | input | 26 | Read byte address |
| req_ready_o | output | 1 | Request accepted this cycle |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_data_o | output | 32 | Read data, little-endian |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| page_i | input | 1 | Upper-page select outside refills |
| page_o | output | 1 | Upper-page chip select |
| sel_o | output | 1 | Refill in progress (flash selected) |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Shifter takes transmit byte |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |

## Verification
The bench uses the default parameters: a 24-bit flash address, a 1024-byte line and 64-byte bursts. Every refill is therefore the real length, and every byte offset of a filled line can be read back and compared with a value computed from the flash address. A shifter model that stalls every fifth byte exercises the burst gate. Configurations with no mode byte and up to seven dummies, two-bus addressing, an upper-page address, and a configuration write in the middle of a refill cover the header variants and the invalidation path.

// File: rtl/flash_cache_pkg.sv
package flash_cache_pkg;

  localparam logic [31:0] CFG_RESET = 32'h03A0_02EB;

  typedef struct packed {
    logic       dual;
    logic       mode_en;
    logic [7:0] mode;
    logic [2:0] dummy;
    logic [7:0] instr;
  } hdr_cfg_t;

  typedef enum logic {FILL_IDLE, FILL_RUN} fill_state_e;

  function automatic hdr_cfg_t decode_cfg(input logic [31:0] c);
    hdr_cfg_t h;
    h.dual    = c[30];
    h.mode_en = c[25];
    h.mode    = c[23:16];
    h.dummy   = c[10:8];
    h.instr   = c[7:0];
    return h;
  endfunction

endpackage

// File: rtl/flash_line_buf.sv
module flash_line_buf #(
  parameter int AW         = 26,
  parameter int LINE_BYTES = 1024,
  parameter int RD_BYTES   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  inval_i,
  input  logic                  set_base_i,
  input  logic [AW-1:0]         base_i,
  input  logic                  wr_en_i,
  input  logic [$clog2(LINE_BYTES)-1:0] wr_idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic [AW-1:0]         look_addr_i,
  output logic                  hit_o,
  input  logic                  rd_en_i,
  output logic [8*RD_BYTES-1:0] rd_data_o
);
  localparam int LW = $clog2(LINE_BYTES);

  logic [7:0]    mem_q [LINE_BYTES];
  logic          valid_q;
  logic [AW-1:0] base_q;
  logic [AW:0]   span_hi;
  logic [AW-1:0] off_full;
  logic [LW-1:0] off;

  assign span_hi  = {1'b0, base_q} + (AW+1)'(LINE_BYTES - RD_BYTES);
  assign hit_o    = valid_q && (look_addr_i >= base_q) && ({1'b0, look_addr_i} <= span_hi);
  assign off_full = look_addr_i - base_q;
  assign off      = off_full[LW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      base_q  <= '0;
    end else if (inval_i) begin
      valid_q <= 1'b0;
    end else if (set_base_i) begin
      valid_q <= 1'b1;
      base_q  <= base_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  for (genvar k = 0; k < RD_BYTES; k++) begin : g_rd
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      byte_q <= '0;
      else if (rd_en_i) byte_q <= mem_q[off + LW'(k)];
    end
    assign rd_data_o[8*k +: 8] = byte_q;
  end

  // R11
  inval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> !hit_o);

endmodule

// File: rtl/flash_fill_seq.sv
module flash_fill_seq
  import flash_cache_pkg::*;
#(
  parameter int FLASH_AW   = 24,
  parameter int AW         = 26,
  parameter int LINE_BYTES = 1024,
  parameter int BURST      = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [AW-1:0]                 addr_i,
  input  hdr_cfg_t                      hcfg_i,
  input  logic                          kill_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [AW-1:0]                 base_o,
  output logic                          upper_o,
  output logic                          wr_en_o,
  output logic [$clog2(LINE_BYTES)-1:0] wr_idx_o,
  output logic [7:0]                    wr_data_o,
  output logic                          tx_valid_o,
  output logic [7:0]                    tx_data_o,
  input  logic                          tx_ready_i,
  input  logic                          rx_valid_i,
  input  logic [7:0]                    rx_data_i
);
  localparam int LW         = $clog2(LINE_BYTES);
  localparam int CW         = $clog2(LINE_BYTES + 16);
  localparam int BW         = $clog2(BURST);
  localparam int ADDR_BYTES = FLASH_AW / 8;

  fill_state_e   state_q;
  hdr_cfg_t      hcfg_q;
  logic [AW-1:0] fa_q;
  logic [CW-1:0] tx_cnt_q, rx_cnt_q;
  logic          killed_q;

  logic [CW-1:0] hdr_len, total, data_sent;
  logic          hdr_phase, mid_burst, tx_fire, rx_take, finish;

  assign busy_o    = (state_q == FILL_RUN);
  assign hdr_len   = CW'(1 + ADDR_BYTES) + CW'(hcfg_q.mode_en) + CW'(hcfg_q.dummy);
  assign total     = hdr_len + CW'(LINE_BYTES);
  assign data_sent = tx_cnt_q - hdr_len;
  assign hdr_phase = tx_cnt_q < hdr_len;
  assign mid_burst = data_sent[BW-1:0] != '0;

  // header bytes go out freely; data bytes wait for the header echo and burst drain
  assign tx_valid_o = busy_o && (tx_cnt_q < total) &&
                      (hdr_phase || ((rx_cnt_q >= hdr_len) && (mid_burst || rx_cnt_q == tx_cnt_q)));
  assign tx_fire    = tx_valid_o && tx_ready_i;
  assign rx_take    = busy_o && rx_valid_i && (rx_cnt_q < total);
  assign finish     = busy_o && (rx_cnt_q == total);

  always_comb begin
    tx_data_o = 8'h00;
    if (tx_cnt_q == '0) tx_data_o = hcfg_q.instr;
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (tx_cnt_q == CW'(b + 1)) tx_data_o = fa_q[8*(ADDR_BYTES-1-b) +: 8];
    end
    if (hcfg_q.mode_en && tx_cnt_q == CW'(ADDR_BYTES + 1)) tx_data_o = hcfg_q.mode;
  end

  assign wr_en_o   = rx_take && (rx_cnt_q >= hdr_len);
  assign wr_idx_o  = LW'(rx_cnt_q - hdr_len);
  assign wr_data_o = rx_data_i;
  assign done_o    = finish && !killed_q && !kill_i;
  assign base_o    = hcfg_q.dual ? {fa_q[AW-2:0], 1'b0} : fa_q;
  assign upper_o   = busy_o && (|fa_q[AW-1:FLASH_AW]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= FILL_IDLE;
      hcfg_q   <= '0;
      fa_q     <= '0;
      tx_cnt_q <= '0;
      rx_cnt_q <= '0;
      killed_q <= 1'b0;
    end else begin
      case (state_q)
        FILL_IDLE: begin
          if (start_i) begin
            state_q  <= FILL_RUN;
            hcfg_q   <= hcfg_i;
            fa_q     <= hcfg_i.dual ? (addr_i >> 1) : addr_i;
            tx_cnt_q <= '0;
            rx_cnt_q <= '0;
            killed_q <= 1'b0;
          end
        end
        default: begin
          if (tx_fire) tx_cnt_q <= tx_cnt_q + 1'b1;
          if (rx_take) rx_cnt_q <= rx_cnt_q + 1'b1;
          if (kill_i)  killed_q <= 1'b1;
          if (finish)  state_q  <= FILL_IDLE;
        end
      endcase
    end
  end

  // R8
  burst_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (rx_cnt_q <= tx_cnt_q) && ((tx_cnt_q - rx_cnt_q) <= CW'(BURST)));

  // R7
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_cnt_q >= CW'(1 + ADDR_BYTES) + CW'(hcfg_q.mode_en)) |-> tx_data_o == 8'h00);

  // R8
  rx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> rx_cnt_q <= total);

endmodule

// File: rtl/flash_read_cache.sv
module flash_read_cache
  import flash_cache_pkg::*;
#(
  parameter int FLASH_AW   = 24,
  parameter int LINE_BYTES = 1024,
  parameter int BURST      = 64,
  parameter int AW         = FLASH_AW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  output logic          req_ready_o,
  output logic          rsp_valid_o,
  output logic [31:0]   rsp_data_o,
  input  logic          cfg_we_i,
  input  logic [31:0]   cfg_wdata_i,
  input  logic          page_i,
  output logic          page_o,
  output logic          sel_o,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  input  logic          tx_ready_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i
);
  localparam int LW = $clog2(LINE_BYTES);

  logic [31:0]   cfg_q;
  logic          rsp_valid_q;
  logic          hit, busy, start, fill_done, upper, wr_en;
  logic [LW-1:0] wr_idx;
  logic [7:0]    wr_data;
  logic [AW-1:0] fill_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= CFG_RESET;
    else if (cfg_we_i) cfg_q <= cfg_wdata_i;
  end

  assign req_ready_o = !busy && hit;
  assign start       = !busy && req_valid_i && !hit && !cfg_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsp_valid_q <= 1'b0;
    else         rsp_valid_q <= req_valid_i && req_ready_o;
  end

  assign rsp_valid_o = rsp_valid_q;
  assign sel_o       = busy;
  assign page_o      = busy ? upper : page_i;

  flash_line_buf #(
    .AW         (AW),
    .LINE_BYTES (LINE_BYTES),
    .RD_BYTES   (4)
  ) u_line (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .inval_i     (cfg_we_i | start),
    .set_base_i  (fill_done),
    .base_i      (fill_base),
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_data_i   (wr_data),
    .look_addr_i (req_addr_i),
    .hit_o       (hit),
    .rd_en_i     (req_valid_i && req_ready_o),
    .rd_data_o   (rsp_data_o)
  );

  flash_fill_seq #(
    .FLASH_AW   (FLASH_AW),
    .AW         (AW),
    .LINE_BYTES (LINE_BYTES),
    .BURST      (BURST)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .addr_i     (req_addr_i),
    .hcfg_i     (decode_cfg(cfg_q)),
    .kill_i     (cfg_we_i),
    .busy_o     (busy),
    .done_o     (fill_done),
    .base_o     (fill_base),
    .upper_o    (upper),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .tx_ready_i (tx_ready_i),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i)
  );

  // R11
  cfg_inval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_we_i) |-> !req_ready_o);

  // R2
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i && req_ready_o));

  // R12
  miss_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o && !sel_o && !cfg_we_i) |=> sel_o && !req_ready_o);

endmodule

// File: tb/sim_flash_read_cache.sv
module sim_flash_read_cache;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [25:0] req_addr_i = '0;
  logic        req_ready_o, rsp_valid_o;
  logic [31:0] rsp_data_o;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic        page_i = 1'b0;
  logic        page_o, sel_o, tx_valid_o;
  logic [7:0]  tx_data_o;
  logic        tx_ready_i;
  logic        rx_valid_i;
  logic [7:0]  rx_data_i;

  always #4 clk_i = ~clk_i;

  flash_read_cache u0 (.*);

  int checks = 0;
  int errors = 0;

  // flash model expectations, set by the stimulus
  int          hdr_exp = 7;
  logic [23:0] dat_base = '0;

  // shifter and flash model
  logic [7:0] hdr_seen [16];
  int         m, tx_total, fills, cyc;
  logic       sel_q, page_seen;

  function automatic logic [7:0] fbyte(input logic p, input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ (p ? 8'hA5 : 8'h3C);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_i <= 1'b0; rx_data_i <= '0; m <= 0; tx_total <= 0;
      fills <= 0; cyc <= 0; sel_q <= 1'b0; tx_ready_i <= 1'b0; page_seen <= 1'b0;
    end else begin
      cyc        <= cyc + 1;
      tx_ready_i <= (cyc % 5) != 4;
      sel_q      <= sel_o;
      if (sel_o && !sel_q) fills <= fills + 1;
      rx_valid_i <= 1'b0;
      if (!sel_o) m <= 0;
      else if (tx_valid_o && tx_ready_i) begin
        if (m < 16) hdr_seen[m] <= tx_data_o;
        page_seen  <= page_o;
        rx_valid_i <= 1'b1;
        rx_data_i  <= (m < hdr_exp) ? 8'hFF : fbyte(page_o, dat_base + 24'(m - hdr_exp));
        m          <= m + 1;
        tx_total   <= m + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  function automatic logic [31:0] exp_word(input logic p, input logic [23:0] fa,
                                           input logic [25:0] a, input logic [25:0] base);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = fbyte(p, fa + 24'(a - base) + 24'(k));
    return w;
  endfunction

  task automatic rd(input logic [25:0] a, output logic [31:0] d, output int lat);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    #1;
    lat = 0;
    while (!req_ready_o && lat < 20000) begin
      @(negedge clk_i); #1;
      lat++;
    end
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk_eq("R2 rsp_valid", {31'b0, rsp_valid_o}, 32'd1);
    d = rsp_data_o;
  endtask

  task automatic cfg_wr(input logic [31:0] v);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  logic [7:0] eh [16];

  task automatic chk_hdr(input string tag, input int n);
    for (int k = 0; k < n; k++) chk_eq(tag, {24'b0, hdr_seen[k]}, {24'b0, eh[k]});
    chk_eq("R7 byte count", tx_total, n + 1024);
  endtask

  initial begin
    repeat (300000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int lat, f0;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    // R1 idle after reset
    chk_eq("R1 rsp_valid", {31'b0, rsp_valid_o}, 32'd0);
    chk_eq("R1 sel", {31'b0, sel_o}, 32'd0);
    chk_eq("R1 tx_valid", {31'b0, tx_valid_o}, 32'd0);
    chk_eq("R1 ready", {31'b0, req_ready_o}, 32'd0);

    // R1 R5 R6 R7 reset config header
    hdr_exp = 7; dat_base = 24'h000100;
    rd(26'h100, d, lat);
    eh[0]=8'hEB; eh[1]=8'h00; eh[2]=8'h01; eh[3]=8'h00; eh[4]=8'hA0; eh[5]=8'h00; eh[6]=8'h00;
    chk_hdr("R1 R5 R6 hdr", 7);
    chk_eq("R3 R8 miss data", d, exp_word(1'b0, 24'h100, 26'h100, 26'h100));
    chk(lat > 1000, "R12 stall", lat, 1000);
    chk_eq("R12 fills", fills, 1);
    chk_eq("R9 page low", {31'b0, page_seen}, 32'd0);

    // R2 R3 every offset of the line
    for (int o = 0; o <= 1020; o++) begin
      rd(26'h100 + 26'(o), d, lat);
      chk_eq("R3 sweep", d, exp_word(1'b0, 24'h100, 26'h100 + 26'(o), 26'h100));
    end
    chk_eq("R2 no refill on hits", fills, 1);

    // R2 R10 just past the end, then just below the base
    dat_base = 24'h0004FD;
    rd(26'h4FD, d, lat);
    chk_eq("R2 above miss", fills, 2);
    chk_eq("R10 data", d, exp_word(1'b0, 24'h4FD, 26'h4FD, 26'h4FD));
    dat_base = 24'h0004FC;
    rd(26'h4FC, d, lat);
    chk_eq("R2 below miss", fills, 3);
    chk_eq("R10 data low", d, exp_word(1'b0, 24'h4FC, 26'h4FC, 26'h4FC));

    // R11 config write invalidates; R6 R7 no mode, no dummies; R9 restore
    page_i = 1'b1;
    cfg_wr(32'h0000_0003);
    @(negedge clk_i); #1;
    chk_eq("R9 page follows input", {31'b0, page_o}, 32'd1);
    hdr_exp = 4;
    rd(26'h4FC, d, lat);
    chk_eq("R11 invalidated", fills, 4);
    eh[0]=8'h03; eh[1]=8'h00; eh[2]=8'h04; eh[3]=8'hFC;
    chk_hdr("R5 R6 short hdr", 4);
    chk_eq("R9 page during fill", {31'b0, page_seen}, 32'd0);
    chk_eq("R9 page restored", {31'b0, page_o}, 32'd1);
    chk_eq("R8 short data", d, exp_word(1'b0, 24'h4FC, 26'h4FC, 26'h4FC));

    // R9 upper page address
    page_i = 1'b0;
    dat_base = 24'h000010;
    rd(26'h100_0010, d, lat);
    eh[0]=8'h03; eh[1]=8'h00; eh[2]=8'h00; eh[3]=8'h10;
    chk_hdr("R5 upper hdr", 4);
    chk_eq("R9 upper page", {31'b0, page_seen}, 32'd1);
    chk_eq("R9 page back", {31'b0, page_o}, 32'd0);
    chk_eq("R9 upper data", d, exp_word(1'b1, 24'h10, 26'h100_0010, 26'h100_0010));

    // R4 R6 R7 R10 two buses, mode byte, seven dummies
    cfg_wr(32'h425C_076B);
    hdr_exp = 12; dat_base = 24'h001001;
    rd(26'h2003, d, lat);
    eh[0]=8'h6B; eh[1]=8'h00; eh[2]=8'h10; eh[3]=8'h01; eh[4]=8'h5C;
    for (int k = 5; k < 12; k++) eh[k] = 8'h00;
    chk_hdr("R4 R6 R7 dual hdr", 12);
    chk_eq("R4 dual data", d, exp_word(1'b0, 24'h1001, 26'h2003, 26'h2002));
    f0 = fills;
    rd(26'h2002, d, lat);
    chk_eq("R10 base hit", d, exp_word(1'b0, 24'h1001, 26'h2002, 26'h2002));
    rd(26'h23FE, d, lat);
    chk_eq("R10 top hit", d, exp_word(1'b0, 24'h1001, 26'h23FE, 26'h2002));
    chk_eq("R10 no refill", fills, f0);
    dat_base = 24'h0011FF;
    rd(26'h23FF, d, lat);
    chk_eq("R10 past top", fills, f0 + 1);
    chk_eq("R4 second dual", d, exp_word(1'b0, 24'h11FF, 26'h23FF, 26'h23FE));

    // R11 config write during refill discards that fill
    f0 = fills;
    fork
      rd(26'h3000, d, lat);
      begin
        wait (sel_o);
        repeat (200) @(negedge clk_i);
        hdr_exp = 7; dat_base = 24'h003000;
        cfg_wr(32'h03A0_02EB);
      end
    join
    chk_eq("R11 refill repeated", fills, f0 + 2);
    eh[0]=8'hEB; eh[1]=8'h00; eh[2]=8'h30; eh[3]=8'h00; eh[4]=8'hA0; eh[5]=8'h00; eh[6]=8'h00;
    chk_hdr("R11 new hdr", 7);
    chk_eq("R11 data", d, exp_word(1'b0, 24'h3000, 26'h3000, 26'h3000));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule